// File: doc/BRIEF.md
# Pseudorandom Test Pattern Generator

This block is a four-stage linear feedback shift register. It produces a stream of pseudorandom test vectors for a combinational circuit under test. The four state bits x3..x0 form the vector that is applied to that circuit. The serial feedback bit f is the exclusive OR of the top stage and the bottom stage. On each enabled clock the contents move one place toward the low stage, and f enters the top stage. With these taps the register runs through every nonzero pattern once, so the sequence is 15 states long.

A control decoder turns the inputs into one of four named actions:

- CTL_INIT: synchronous reset, which loads 1000.
- CTL_LOAD: takes a seed.
- CTL_STEP: advances the register one state.
- CTL_HOLD: keeps the present state.

The legal transitions are as follows:

- Any action leads to CTL_INIT while `rst` is high.
- With reset low, `seed_load` selects CTL_LOAD.
- With reset and load low, `en` selects CTL_STEP.
- When no input is high, the action is CTL_HOLD.

A seed of all zeros is replaced by 1000. This keeps the register out of the lock-up state.

Top module: `ptg_gen`

## Requirements
- R1: One clock after `rst` is sampled high, x reads 1000 (x3 is bit 3) and f reads 1.
- R2: f always equals x3 XOR x0 of the present state.
- R3: On a clock with `en` high and no reset or load, the next state is {f, x3, x2, x1}: x3 takes f and each lower stage takes the old value of the stage above it.
- R4: Stepping from 1000 yields 1100, 1110, 1111, 0111, 1011, 0101, 1010, 1101, 0110, 0011, 1001, 0100, 0010, 0001, and then 1000 again on the 15th step.
- R5: With `en`, `seed_load` and `rst` all low, x keeps its value across clocks.
- R6: With `seed_load` high and a nonzero `seed`, x equals `seed` after the clock, whatever the level of `en`.
- R7: With `seed_load` high and `seed` equal to 0000, x becomes 1000 after the clock.
- R8: After the first reset, x never reads 0000.
- R9: When `rst` and `seed_load` are high on the same clock, the reset value 1000 wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; loads 1000 |
| en | input | 1 | Advance the register one state when high |
| seed_load | input | 1 | Load `seed` on the next edge |
| seed | input | 4 | Seed value; 0000 is replaced by 1000 |
| x | output | 4 | Parallel state x3..x0, the test vector |
| f | output | 1 | Serial feedback bit, x3 XOR x0 |

## Verification
The bench builds the generator with its default parameters: a width of four and a reset seed of 1000. Under these defaults the full 15-state cycle is short enough to walk completely, including the return to the start pattern. The bench also checks the hold, load and priority rules at several points in that cycle. It drives the zero seed directly, and it applies a load together with a reset, so that the lock-up guard and the priority of reset are both checked at the ports.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    // Action decoded for each clock edge
    typedef enum logic [1:0] {
        CTL_HOLD = 2'd0,
        CTL_STEP = 2'd1,
        CTL_LOAD = 2'd2,
        CTL_INIT = 2'd3
    } ctl_e;

endpackage

// File: rtl/ptg_ctrl.sv
module ptg_ctrl
    import ptg_pkg::*;
(
    input  logic rst,
    input  logic load,
    input  logic en,
    output ctl_e ctl
);

    // Priority: reset, then load, then enable
    always_comb begin
        unique casez ({rst, load, en})
            3'b1??:  ctl = CTL_INIT;
            3'b01?:  ctl = CTL_LOAD;
            3'b001:  ctl = CTL_STEP;
            default: ctl = CTL_HOLD;
        endcase
    end

endmodule

// File: rtl/ptg_seed_guard.sv
module ptg_seed_guard #(
    parameter int              WIDTH      = 4,
    parameter logic [WIDTH-1:0] RESET_SEED = 4'b1000
) (
    input  logic [WIDTH-1:0] seed_in,
    output logic [WIDTH-1:0] seed_safe
);

    // An all-zero seed would lock the register; substitute the reset seed
    always_comb begin
        if (seed_in == '0) seed_safe = RESET_SEED;
        else               seed_safe = seed_in;
    end

endmodule

// File: rtl/ptg_shift_reg.sv
module ptg_shift_reg
    import ptg_pkg::*;
#(
    parameter int              WIDTH      = 4,
    parameter logic [WIDTH-1:0] RESET_SEED = 4'b1000
) (
    input  logic             clk,
    input  ctl_e             ctl,
    input  logic [WIDTH-1:0] seed_safe,
    output logic [WIDTH-1:0] q,
    output logic             fb
);

    localparam int TAP_HI = WIDTH - 1;
    localparam int TAP_LO = 0;

    assign fb = q[TAP_HI] ^ q[TAP_LO];

    // State register
    always_ff @(posedge clk) begin
        unique case (ctl)
            CTL_INIT: q <= RESET_SEED;
            CTL_LOAD: q <= seed_safe;
            CTL_STEP: q <= {fb, q[WIDTH-1:1]};
            CTL_HOLD: q <= q;
            default:  q <= q;
        endcase
    end

endmodule

// File: rtl/ptg_gen.sv
module ptg_gen
    import ptg_pkg::*;
#(
    parameter int              WIDTH      = 4,
    parameter logic [WIDTH-1:0] RESET_SEED = 4'b1000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             seed_load,
    input  logic [WIDTH-1:0] seed,
    output logic [WIDTH-1:0] x,
    output logic             f
);

    ctl_e             ctl;
    logic [WIDTH-1:0] seed_safe;

    ptg_ctrl u_ctrl (
        .rst  (rst),
        .load (seed_load),
        .en   (en),
        .ctl  (ctl)
    );

    ptg_seed_guard #(
        .WIDTH      (WIDTH),
        .RESET_SEED (RESET_SEED)
    ) u_guard (
        .seed_in   (seed),
        .seed_safe (seed_safe)
    );

    ptg_shift_reg #(
        .WIDTH      (WIDTH),
        .RESET_SEED (RESET_SEED)
    ) u_sr (
        .clk       (clk),
        .ctl       (ctl),
        .seed_safe (seed_safe),
        .q         (x),
        .fb        (f)
    );

endmodule

// File: rtl/ptg_gen_chk.sv
module ptg_gen_chk #(
    parameter int              WIDTH      = 4,
    parameter logic [WIDTH-1:0] RESET_SEED = 4'b1000
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             seed_load,
    input logic [WIDTH-1:0] seed,
    input logic [WIDTH-1:0] x,
    input logic             f
);

    logic seen_rst = 1'b0;
    always_ff @(posedge clk) if (rst) seen_rst <= 1'b1;

    AST_RESET_SEED: assert property (@(posedge clk)
        rst |=> (x == RESET_SEED)); // R1

    AST_RESET_WINS: assert property (@(posedge clk)
        (rst && seed_load) |=> (x == RESET_SEED)); // R9

    AST_STEP_SHIFT: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (en && !seed_load) |=> (x == {$past(f), $past(x[WIDTH-1:1])})); // R3

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (!en && !seed_load) |=> $stable(x)); // R5

    AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (seed_load && seed != '0) |=> (x == $past(seed))); // R6

    AST_ZERO_SEED_SUB: assert property (@(posedge clk) disable iff (rst || !seen_rst)
        (seed_load && seed == '0) |=> (x == RESET_SEED)); // R7

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
        seen_rst |-> (x != '0)); // R8

endmodule

bind ptg_gen ptg_gen_chk #(
    .WIDTH      (WIDTH),
    .RESET_SEED (RESET_SEED)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .seed_load (seed_load),
    .seed      (seed),
    .x         (x),
    .f         (f)
);

// File: tb/ptg_gen_test.sv
`timescale 1ns/1ps
module ptg_gen_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       seed_load = 1'b0;
    logic [3:0] seed = 4'b0000;
    logic [3:0] x;
    logic       f;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk; // 125 MHz

    ptg_gen uut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .seed_load (seed_load),
        .seed      (seed),
        .x         (x),
        .f         (f)
    );

    // Expected cycle from the R4 list, index 15 is the return to start
    localparam logic [3:0] SEQ [0:15] = '{
        4'b1000, 4'b1100, 4'b1110, 4'b1111, 4'b0111, 4'b1011, 4'b0101, 4'b1010,
        4'b1101, 4'b0110, 4'b0011, 4'b1001, 4'b0100, 4'b0010, 4'b0001, 4'b1000
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge
    task automatic apply(input logic r, input logic ld, input logic e, input logic [3:0] s);
        rst = r; seed_load = ld; en = e; seed = s;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        apply(1'b1, 1'b0, 1'b0, 4'b0000);
        // R1 reset state and f
        chk("R1 reset x", x, 4'b1000);
        chk("R1 reset f", {3'b000, f}, 4'b0001);

        // R4 / R3 / R2 / R8 walk of the full cycle
        for (int i = 0; i < 16; i++) begin
            chk("R4 sequence", x, SEQ[i]);
            chk("R2 feedback", {3'b000, f}, {3'b000, SEQ[i][3] ^ SEQ[i][0]});
            if (x == 4'b0000) chk("R8 nonzero", x, SEQ[i]);
            if (i < 15) apply(1'b0, 1'b0, 1'b1, 4'b0000);
        end

        // R5 hold with enable low, mid-cycle
        apply(1'b0, 1'b0, 1'b1, 4'b0000); // -> 1100
        apply(1'b0, 1'b0, 1'b1, 4'b0000); // -> 1110
        for (int k = 0; k < 3; k++) begin
            apply(1'b0, 1'b0, 1'b0, 4'b1111);
            chk("R5 hold", x, 4'b1110);
        end

        // R6 load with enable low, then R3 single step
        apply(1'b0, 1'b1, 1'b0, 4'b0101);
        chk("R6 load en low", x, 4'b0101);
        apply(1'b0, 1'b0, 1'b1, 4'b0000);
        chk("R3 step after load", x, 4'b1010);

        // R6 load overrides enable
        apply(1'b0, 1'b1, 1'b1, 4'b0011);
        chk("R6 load en high", x, 4'b0011);
        apply(1'b0, 1'b0, 1'b1, 4'b0000);
        chk("R3 step from 0011", x, 4'b1001);

        // R7 zero seed substituted
        apply(1'b0, 1'b1, 1'b1, 4'b0000);
        chk("R7 zero seed", x, 4'b1000);
        chk("R8 not zero after zero seed", {3'b000, x == 4'b0000}, 4'b0000);

        // R9 reset beats load
        apply(1'b0, 1'b1, 1'b0, 4'b0110);
        apply(1'b1, 1'b1, 1'b1, 4'b0110);
        chk("R9 reset over load", x, 4'b1000);

        // R1 reset in the middle of a run
        apply(1'b0, 1'b0, 1'b1, 4'b0000);
        apply(1'b0, 1'b0, 1'b1, 4'b0000);
        apply(1'b1, 1'b0, 1'b1, 4'b0000);
        chk("R1 reset mid-run", x, 4'b1000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule